// File: doc/BRIEF.md
# Register to Reconfiguration-Port Bridge

This block sits on a simple memory-mapped register bus and gives software access to the 16-bit configuration registers inside a clock-generator primitive. The primitive exposes those registers through a dynamic reconfiguration port (DRP). That port has an enable, a write-enable, an address, write data, read data and a ready handshake. Software starts each transaction with one packed control word. This word holds a start bit, a direction bit, the register address and the write data. Software then polls a single status word, which returns a busy flag together with the data from the last read.

A separate reset register holds two release bits. One releases the logic around the primitive. The other takes the primitive itself out of reset, but only when the first bit is also set. Any partial-field update is done by software as a read, a mask, a merge and a write. The bridge moves only whole 16-bit words.

Top module: `drp_bridge`

## Requirements
- R1: After reset, drp_en is 0, the status word at offset 0x74 reads 0 (busy bit 16 clear, data bits 15:0 zero), the reset register at 0x40 reads 0, and sys_release and prim_release are both 0.
- R2: A write to offset 0x70 with bit 29 set, accepted while not busy, raises drp_en for exactly one clock cycle, starting the cycle after the write. During that cycle drp_addr carries control bits 22:16 and drp_di carries control bits 15:0.
- R3: While drp_en is high, drp_we is the inverse of control bit 28 (bit 28 set means read, bit 28 clear means write).
- R4: Status bit 16 (busy) is set in the same cycle as the drp_en pulse. It stays set until the cycle after drp_rdy is sampled high.
- R5: For a read transaction, drp_do is captured into status bits 15:0 on the edge where drp_rdy is seen. A write transaction leaves those bits unchanged.
- R6: A write to 0x70 while busy is ignored. No new pulse is issued, the transaction in flight completes unchanged, and the control readback keeps its previous value.
- R7: Reading offset 0x70 returns the last accepted control word. A control write with bit 29 clear is stored but starts no transaction.
- R8: The reset register at 0x40 reads back bits 1:0 as written. sys_release equals bit 0, and prim_release is high only when both bit 0 and bit 1 are 1.
- R9: Reads of any other offset return 0, and writes to any other offset change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid while bus_rd is high, zero otherwise |
| drp_en | output | 1 | One-cycle transaction enable to the primitive |
| drp_we | output | 1 | Write-enable qualifying drp_en |
| drp_addr | output | 7 | Primitive register address |
| drp_di | output | 16 | Data written to the primitive |
| drp_do | input | 16 | Data read from the primitive |
| drp_rdy | input | 1 | Transaction-complete pulse from the primitive |
| sys_release | output | 1 | Releases the surrounding logic from reset |
| prim_release | output | 1 | Releases the clock primitive from reset |

## Verification
The hardest case to reach is a control write that arrives while a transaction is still in flight. A well-behaved driver never does this, so the bench has to break the polling rule on purpose. To do so, it sets the primitive model to a long ready latency, starts a read, and at once writes a second control word that targets a different address. Afterwards it confirms four things: only one enable pulse appeared, the read data belongs to the first address, the control readback was not overwritten, and the second address was never written in the model.

// File: rtl/drp_bridge.sv
module drp_bridge #(
  parameter int AW = 7,
  parameter int DW = 16,
  parameter int OW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_wr,
  input  logic          bus_rd,
  input  logic [OW-1:0] bus_addr,
  input  logic [31:0]   bus_wdata,
  output logic [31:0]   bus_rdata,
  output logic          drp_en,
  output logic          drp_we,
  output logic [AW-1:0] drp_addr,
  output logic [DW-1:0] drp_di,
  input  logic [DW-1:0] drp_do,
  input  logic          drp_rdy,
  output logic          sys_release,
  output logic          prim_release
);

  localparam logic [OW-1:0] CTRL_OFF = OW'(8'h70);
  localparam logic [OW-1:0] STAT_OFF = OW'(8'h74);
  localparam logic [OW-1:0] RST_OFF  = OW'(8'h40);
  localparam int SEL_BIT  = 29;
  localparam int RD_BIT   = 28;
  localparam int ADDR_LSB = 16;
  localparam int BUSY_BIT = DW;

  logic [31:0]   ctrl_q;
  logic [DW-1:0] rdata_q;
  logic          busy_q;
  logic          en_q;
  logic [1:0]    rst_q;

  wire ctrl_acc = bus_wr && (bus_addr == CTRL_OFF) && !busy_q;
  wire launch   = ctrl_acc && bus_wdata[SEL_BIT];
  wire done     = busy_q && drp_rdy;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q  <= '0;
      rdata_q <= '0;
      busy_q  <= 1'b0;
      en_q    <= 1'b0;
      rst_q   <= '0;
    end else begin
      en_q <= launch;
      if (ctrl_acc) ctrl_q <= bus_wdata;
      if (launch) busy_q <= 1'b1;
      else if (done) busy_q <= 1'b0;
      if (done && ctrl_q[RD_BIT]) rdata_q <= drp_do;
      if (bus_wr && bus_addr == RST_OFF) rst_q <= bus_wdata[1:0];
    end
  end

  assign drp_en       = en_q;
  assign drp_we       = en_q & ~ctrl_q[RD_BIT];
  assign drp_addr     = ctrl_q[ADDR_LSB +: AW];
  assign drp_di       = ctrl_q[DW-1:0];
  assign sys_release  = rst_q[0];
  assign prim_release = rst_q[0] & rst_q[1];

  always_comb begin
    bus_rdata = '0;
    if (bus_rd) begin
      case (bus_addr)
        CTRL_OFF: bus_rdata = ctrl_q;
        STAT_OFF: begin
          bus_rdata[DW-1:0]     = rdata_q;
          bus_rdata[BUSY_BIT]   = busy_q;
        end
        RST_OFF:  bus_rdata[1:0] = rst_q;
        default:  bus_rdata = '0;
      endcase
    end
  end

  AST_EN_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    drp_en |=> !drp_en); // R2
  AST_BUSY_WITH_EN: assert property (@(posedge clk) disable iff (!rst_n)
    drp_en |-> busy_q); // R4
  AST_RDY_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && drp_rdy && !drp_en) |=> !busy_q); // R4
  AST_BUSY_IGNORE: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && bus_wr && bus_addr == CTRL_OFF) |=> ($stable(ctrl_q) && !drp_en)); // R6
  AST_WE_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    drp_we |-> drp_en); // R3
  AST_PRIM_NEEDS_SYS: assert property (@(posedge clk) disable iff (!rst_n)
    prim_release |-> sys_release); // R8

endmodule

// File: tb/drp_bridge_test.sv
`timescale 1ns/1ps
module drp_bridge_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic drp_en, drp_we, drp_rdy;
  logic [6:0] drp_addr;
  logic [15:0] drp_di, drp_do;
  logic sys_release, prim_release;

  always #2.5 clk = ~clk;

  drp_bridge uut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .drp_en(drp_en), .drp_we(drp_we), .drp_addr(drp_addr), .drp_di(drp_di),
    .drp_do(drp_do), .drp_rdy(drp_rdy),
    .sys_release(sys_release), .prim_release(prim_release)
  );

  int checks = 0, fails = 0;
  int lat = 1;
  int cnt = 0;
  int pulses = 0, long_pulses = 0;
  logic prev_en = 1'b0;
  logic last_we;
  logic [6:0] last_addr, pend_addr;
  logic [15:0] last_di;
  logic [15:0] pmem [128];
  logic [15:0] shadow [128];
  logic rdy_m = 1'b0;
  logic [15:0] do_m = '0;
  assign drp_rdy = rdy_m;
  assign drp_do = do_m;

  initial for (int i = 0; i < 128; i++) begin pmem[i] = '0; shadow[i] = '0; end

  always @(negedge clk) begin
    rdy_m <= 1'b0;
    if (prev_en && drp_en) long_pulses++;
    prev_en <= drp_en;
    if (drp_en) begin
      pulses++;
      last_we = drp_we; last_addr = drp_addr; last_di = drp_di;
      if (drp_we) pmem[drp_addr] <= drp_di;
      pend_addr <= drp_addr;
      cnt <= lat;
    end else if (cnt != 0) begin
      cnt <= cnt - 1;
      if (cnt == 1) begin rdy_m <= 1'b1; do_m <= pmem[pend_addr]; end
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    bus_rd = 1'b1; bus_addr = a;
    #0.5 d = bus_rdata;
    bus_rd = 1'b0;
  endtask

  task automatic wait_idle(output logic [31:0] st);
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      rd(8'h74, st);
      if (!st[16]) return;
    end
  endtask

  function automatic logic [31:0] cword(input bit sel, input bit r, input logic [6:0] a, input logic [15:0] d);
    return {2'b00, sel, r, 5'b0, a, d};
  endfunction

  // {read, latency[3:0], addr[6:0], data[15:0]}
  localparam logic [27:0] VEC [8] = '{
    {1'b0, 4'd1, 7'h08, 16'h1234},
    {1'b1, 4'd2, 7'h08, 16'h0000},
    {1'b0, 4'd5, 7'h4e, 16'hbeef},
    {1'b0, 4'd1, 7'h7f, 16'hffff},
    {1'b1, 4'd7, 7'h4e, 16'h0000},
    {1'b1, 4'd1, 7'h7f, 16'h5555},
    {1'b1, 4'd3, 7'h00, 16'h0000},
    {1'b0, 4'd2, 7'h00, 16'ha5a5}
  };

  logic [31:0] v, st;
  int p0;

  initial begin
    #(20000 * 5);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    rd(8'h74, v); chk(v == 0, "R1 status after reset", v, 0);
    rd(8'h40, v); chk(v == 0, "R1 reset reg after reset", v, 0);
    chk(!drp_en && !sys_release && !prim_release, "R1 outputs after reset",
        {drp_en, sys_release, prim_release}, 0);

    for (int k = 0; k < 8; k++) begin
      logic r; logic [6:0] a; logic [15:0] d;
      r = VEC[k][27]; lat = int'(VEC[k][26:23]); a = VEC[k][22:16]; d = VEC[k][15:0];
      p0 = pulses;
      wr(8'h70, cword(1'b1, r, a, d));
      rd(8'h74, v); chk(v[16] == 1'b1, "R4 busy after launch", v, 32'h10000);
      wait_idle(st);
      chk(pulses == p0 + 1 && long_pulses == 0, "R2 single pulse", pulses - p0, 1);
      chk(last_addr == a, "R2 address", last_addr, a);
      chk(last_we == !r, "R3 write-enable", last_we, !r);
      if (!r) begin
        chk(last_di == d, "R2 write data", last_di, d);
        shadow[a] = d;
      end else begin
        chk(st[15:0] == shadow[a], "R5 read data", st[15:0], shadow[a]);
      end
      rd(8'h70, v); chk(v == cword(1'b1, r, a, d), "R7 control readback", v, cword(1'b1, r, a, d));
    end

    // R5: a write leaves the last read data in place (last vector read 0x00 = 0)
    lat = 2;
    wr(8'h70, cword(1'b1, 1'b1, 7'h4e, 16'h0));
    wait_idle(st);
    wr(8'h70, cword(1'b1, 1'b0, 7'h11, 16'h7777));
    shadow[7'h11] = 16'h7777;
    wait_idle(st);
    chk(st[15:0] == 16'hbeef, "R5 status kept over write", st[15:0], 16'hbeef);

    // R6: control write while busy
    lat = 12;
    p0 = pulses;
    wr(8'h70, cword(1'b1, 1'b1, 7'h08, 16'h0));
    wr(8'h70, cword(1'b1, 1'b0, 7'h09, 16'hdead));
    rd(8'h70, v);
    chk(v == cword(1'b1, 1'b1, 7'h08, 16'h0), "R6 control not overwritten", v, cword(1'b1, 1'b1, 7'h08, 16'h0));
    wait_idle(st);
    chk(pulses == p0 + 1, "R6 no second pulse", pulses - p0, 1);
    chk(st[15:0] == 16'h1234, "R6 read in flight intact", st[15:0], 16'h1234);
    lat = 1;
    wr(8'h70, cword(1'b1, 1'b1, 7'h09, 16'h0));
    wait_idle(st);
    chk(st[15:0] == 16'h0000, "R6 ignored write not applied", st[15:0], 0);

    // R7: start bit clear stores but launches nothing
    p0 = pulses;
    wr(8'h70, cword(1'b0, 1'b0, 7'h22, 16'h4321));
    repeat (4) @(negedge clk);
    rd(8'h74, v);
    chk(pulses == p0 && !v[16], "R7 no launch without start bit", pulses - p0, 0);
    rd(8'h70, v); chk(v == cword(1'b0, 1'b0, 7'h22, 16'h4321), "R7 stored word", v, cword(1'b0, 1'b0, 7'h22, 16'h4321));

    // R8: reset register
    wr(8'h40, 32'h2);
    rd(8'h40, v);
    chk(v == 2 && !sys_release && !prim_release, "R8 primitive bit alone", {v[1:0], sys_release, prim_release}, {2'd2, 2'b00});
    wr(8'h40, 32'h3);
    chk(sys_release && prim_release, "R8 both released", {sys_release, prim_release}, 2'b11);
    wr(8'h40, 32'h1);
    rd(8'h40, v);
    chk(v == 1 && sys_release && !prim_release, "R8 system only", {v[1:0], sys_release, prim_release}, {2'd1, 2'b10});

    // R9: unmapped offsets
    p0 = pulses;
    wr(8'h44, 32'hffff_ffff);
    wr(8'h6c, 32'h2000_0000);
    rd(8'h44, v); chk(v == 0, "R9 unmapped read", v, 0);
    rd(8'h70, v); chk(v == cword(1'b0, 1'b0, 7'h22, 16'h4321) && pulses == p0, "R9 control untouched", v, cword(1'b0, 1'b0, 7'h22, 16'h4321));
    rd(8'h40, v); chk(v == 1, "R9 reset reg untouched", v, 1);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule